// File: doc/BRIEF.md
# Programmable Raster Video Timing Generator

This block produces the horizontal and vertical timing for a raster display, such as a VGA monitor or an LCD panel, in the pixel clock domain. Software programs four values for each axis: the sync pulse width, the delay from the start of sync to the first visible element, the number of visible elements, and the total length. Lines are counted in pixels and frames are counted in lines. From these values the block builds horizontal, vertical and composite sync, a blanking signal, a visible-area gate, and single-cycle end-of-line and end-of-frame pulses.

Each axis runs in a fixed order. Sync comes first and starts at element 0. The visible region starts at the programmed delay, counted from element 0. The axis then idles until the total length is reached and wraps to zero. The vertical counter moves only at the end of each line. Sync and blank outputs each have their own polarity select. A video-enable input is registered on the pixel clock. While that registered enable is low, the generator is held at its start point and every output is inactive. The first cycle after enabling is pixel 0 of line 0, with both syncs active.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal position runs from 0 to hline_len_i-1 and then wraps to 0, so a line lasts hline_len_i pixel clocks (hline_len_i >= 2 assumed).
- R2: The active horizontal sync covers pixels 0 to hsync_width_i-1. A width of 0 gives no horizontal sync.
- R3: The horizontal visible gate is active for pixels p with hgate_delay_i <= p < hgate_delay_i + hgate_len_i.
- R4: The line counter advances only at the last pixel of a line and wraps after vframe_len_i lines. Vertical sync covers lines 0 to vsync_width_i-1. The vertical gate covers lines vgate_delay_i to vgate_delay_i+vgate_len_i-1.
- R5: gate_o is high exactly when both the horizontal and vertical gates are active.
- R6: Blank is active whenever gate_o is low.
- R7: Composite sync is active when horizontal sync or vertical sync is active.
- R8: Each of hsync_o, vsync_o, csync_o and blank_o equals its active condition XOR its polarity input. A polarity bit of 0 gives an active-high output and 1 gives an active-low output.
- R9: eol_o is high for one clock on the last pixel of every line. eof_o is high only on the last pixel of the last line of a frame.
- R10: video_en_i is registered once. While the registered enable is low, gate_o, eol_o and eof_o are 0, the syncs are inactive and blank is active. The first cycle after the registered enable rises is pixel 0 of line 0.
- R11: While rst_ni is low, the outputs show the same idle state as when video is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| video_en_i | input | 1 | Video enable; low holds the generator idle |
| hsync_pol_i | input | 1 | Horizontal sync polarity (1 = active low) |
| hsync_width_i | input | 8 | Horizontal sync width in pixels |
| hgate_delay_i | input | 8 | Sync start to first visible pixel |
| hgate_len_i | input | 16 | Visible pixels per line |
| hline_len_i | input | 16 | Total pixels per line |
| vsync_pol_i | input | 1 | Vertical sync polarity (1 = active low) |
| vsync_width_i | input | 8 | Vertical sync width in lines |
| vgate_delay_i | input | 8 | Sync start to first visible line |
| vgate_len_i | input | 16 | Visible lines per frame |
| vframe_len_i | input | 16 | Total lines per frame |
| csync_pol_i | input | 1 | Composite sync polarity (1 = active low) |
| blank_pol_i | input | 1 | Blank polarity (1 = active low) |
| eol_o | output | 1 | End-of-line pulse |
| eof_o | output | 1 | End-of-frame pulse |
| gate_o | output | 1 | Visible-area gate |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| csync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Blanking signal |

## Verification
All outputs are decoded from the two position counters, so a wrong horizontal count shows up on the sync, gate or eol pins within one line. A wrong line count shows up on vsync_o, gate_o or eof_o within one frame. A bad enable or restart path shifts the whole pattern: the first cycle after enabling no longer shows both syncs active. The bench therefore compares every output pin on every cycle of complete frames against a position model of its own, under several settings.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned SYNC_W = 8;
  localparam int unsigned LEN_W  = 16;
  localparam int unsigned NAX    = 2;   // horizontal, vertical
  localparam int unsigned NPOL   = 4;   // hsync, vsync, csync, blank

  typedef enum logic [1:0] {
    POL_HS = 2'd0,
    POL_VS = 2'd1,
    POL_CS = 2'd2,
    POL_BL = 2'd3
  } pol_idx_e;
endpackage

// File: rtl/rt_run_reg.sv
module rt_run_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic run_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_o <= 1'b0;
    else         run_o <= en_i;
  end
endmodule

// File: rtl/rt_axis.sv
module rt_axis #(
  parameter int unsigned SYNC_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [SYNC_W-1:0] sync_w_i,
  input  logic [SYNC_W-1:0] delay_i,
  input  logic [LEN_W-1:0]  vis_i,
  input  logic [LEN_W-1:0]  total_i,
  output logic              last_o,
  output logic              sync_o,
  output logic              gate_o
);
  localparam int unsigned SUM_W = LEN_W + 1;

  logic [LEN_W-1:0] cnt_q;
  logic [SUM_W-1:0] vis_end;

  assign last_o  = (cnt_q == total_i - LEN_W'(1));
  assign vis_end = SUM_W'(delay_i) + SUM_W'(vis_i);
  assign sync_o  = (cnt_q < LEN_W'(sync_w_i));
  assign gate_o  = (cnt_q >= LEN_W'(delay_i)) && (SUM_W'(cnt_q) < vis_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + LEN_W'(1);
  end
endmodule

// File: rtl/rt_out_stage.sv
module rt_out_stage
  import raster_pkg::*;
(
  input  logic            run_i,
  input  logic            hs_i,
  input  logic            vs_i,
  input  logic            hg_i,
  input  logic            vg_i,
  input  logic [NPOL-1:0] pol_i,
  output logic            gate_o,
  output logic [NPOL-1:0] pin_o
);
  logic [NPOL-1:0] act;

  assign gate_o       = run_i & hg_i & vg_i;
  assign act[POL_HS]  = run_i & hs_i;
  assign act[POL_VS]  = run_i & vs_i;
  assign act[POL_CS]  = run_i & (hs_i | vs_i);
  assign act[POL_BL]  = ~gate_o;

  for (genvar i = 0; i < NPOL; i++) begin : g_pol
    assign pin_o[i] = act[i] ^ pol_i[i];
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              video_en_i,
  input  logic              hsync_pol_i,
  input  logic [SYNC_W-1:0] hsync_width_i,
  input  logic [SYNC_W-1:0] hgate_delay_i,
  input  logic [LEN_W-1:0]  hgate_len_i,
  input  logic [LEN_W-1:0]  hline_len_i,
  input  logic              vsync_pol_i,
  input  logic [SYNC_W-1:0] vsync_width_i,
  input  logic [SYNC_W-1:0] vgate_delay_i,
  input  logic [LEN_W-1:0]  vgate_len_i,
  input  logic [LEN_W-1:0]  vframe_len_i,
  input  logic              csync_pol_i,
  input  logic              blank_pol_i,
  output logic              eol_o,
  output logic              eof_o,
  output logic              gate_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              csync_o,
  output logic              blank_o
);
  logic run;
  logic [NAX-1:0][SYNC_W-1:0] sync_w, delay;
  logic [NAX-1:0][LEN_W-1:0]  vis, total;
  logic [NAX-1:0] step, last, sync_act, gate_act;
  logic [NPOL-1:0] pol, pins;

  rt_run_reg u_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (video_en_i),
    .run_o (run)
  );

  assign sync_w = {vsync_width_i, hsync_width_i};
  assign delay  = {vgate_delay_i, hgate_delay_i};
  assign vis    = {vgate_len_i,   hgate_len_i};
  assign total  = {vframe_len_i,  hline_len_i};
  // axis 0 steps every pixel, axis 1 steps on end of line
  assign step   = {run & last[0], run};

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    rt_axis #(.SYNC_W(SYNC_W), .LEN_W(LEN_W)) u_axis (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (~run),
      .step_i  (step[a]),
      .sync_w_i(sync_w[a]),
      .delay_i (delay[a]),
      .vis_i   (vis[a]),
      .total_i (total[a]),
      .last_o  (last[a]),
      .sync_o  (sync_act[a]),
      .gate_o  (gate_act[a])
    );
  end

  assign pol = {blank_pol_i, csync_pol_i, vsync_pol_i, hsync_pol_i};

  rt_out_stage u_out (
    .run_i (run),
    .hs_i  (sync_act[0]),
    .vs_i  (sync_act[1]),
    .hg_i  (gate_act[0]),
    .vg_i  (gate_act[1]),
    .pol_i (pol),
    .gate_o(gate_o),
    .pin_o (pins)
  );

  assign hsync_o = pins[POL_HS];
  assign vsync_o = pins[POL_VS];
  assign csync_o = pins[POL_CS];
  assign blank_o = pins[POL_BL];
  assign eol_o   = run & last[0];
  assign eof_o   = run & last[0] & last[1];
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic video_en_i,
  input logic hsync_pol_i,
  input logic vsync_pol_i,
  input logic csync_pol_i,
  input logic blank_pol_i,
  input logic eol_o,
  input logic eof_o,
  input logic gate_o,
  input logic hsync_o,
  input logic vsync_o,
  input logic csync_o,
  input logic blank_o
);
  assert_eof_in_eol_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> eol_o);

  assert_blank_vs_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_o ^ blank_pol_i) == !gate_o);

  assert_csync_or_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csync_o ^ csync_pol_i) == ((hsync_o ^ hsync_pol_i) | (vsync_o ^ vsync_pol_i)));

  assert_idle_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !video_en_i |=> (!gate_o && !eol_o && !eof_o && (hsync_o == hsync_pol_i)));

  assert_start_sync_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(video_en_i) |=> ((hsync_o != hsync_pol_i) || !eol_o));
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .video_en_i (video_en_i),
  .hsync_pol_i(hsync_pol_i),
  .vsync_pol_i(vsync_pol_i),
  .csync_pol_i(csync_pol_i),
  .blank_pol_i(blank_pol_i),
  .eol_o      (eol_o),
  .eof_o      (eof_o),
  .gate_o     (gate_o),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .csync_o    (csync_o),
  .blank_o    (blank_o)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic hp = 0, vp = 0, cp = 0, bp = 0;
  logic [7:0]  hsw, hdl, vsw, vdl;
  logic [15:0] hgl, hll, vgl, vfl;
  logic eol, eof, gate, hs, vs, cs, bl;
  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .video_en_i(en),
    .hsync_pol_i(hp), .hsync_width_i(hsw), .hgate_delay_i(hdl),
    .hgate_len_i(hgl), .hline_len_i(hll),
    .vsync_pol_i(vp), .vsync_width_i(vsw), .vgate_delay_i(vdl),
    .vgate_len_i(vgl), .vframe_len_i(vfl),
    .csync_pol_i(cp), .blank_pol_i(bp),
    .eol_o(eol), .eof_o(eof), .gate_o(gate), .hsync_o(hs),
    .vsync_o(vs), .csync_o(cs), .blank_o(bl)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) cyc++;

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      report();
    end
  end

  task automatic idle_check(input string tag);
    chk({tag, " gate"}, gate, 1'b0);
    chk({tag, " eol"}, eol, 1'b0);
    chk({tag, " eof"}, eof, 1'b0);
    chk({tag, " hsync"}, hs, hp);
    chk({tag, " vsync"}, vs, vp);
    chk({tag, " csync"}, cs, cp);
    chk({tag, " blank"}, bl, ~bp);
  endtask

  // compare all pins against the position model for n cycles from position 0
  task automatic run_compare(input int ncyc);
    for (int n = 0; n < ncyc; n++) begin
      int h, v;
      logic ehs, evs, ehg, evg, eg;
      @(negedge clk);
      h = n % int'(hll);
      v = (n / int'(hll)) % int'(vfl);
      ehs = h < int'(hsw);
      evs = v < int'(vsw);
      ehg = (h >= int'(hdl)) && (h < int'(hdl) + int'(hgl));
      evg = (v >= int'(vdl)) && (v < int'(vdl) + int'(vgl));
      eg  = ehg & evg;
      chk("R1 R9 eol", eol, h == int'(hll) - 1);
      chk("R4 R9 eof", eof, (h == int'(hll) - 1) && (v == int'(vfl) - 1));
      chk("R2 R8 hsync", hs, ehs ^ hp);
      chk("R4 R8 vsync", vs, evs ^ vp);
      chk("R7 R8 csync", cs, (ehs | evs) ^ cp);
      chk("R3 R4 R5 gate", gate, eg);
      chk("R6 R8 blank", bl, (~eg) ^ bp);
    end
  endtask

  task automatic start_video();
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic stop_video();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    idle_check("R11 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R10 disabled");
  endtask

  task automatic t_basic();
    hp = 0; vp = 0; cp = 0; bp = 0;
    start_video();
    run_compare(2 * int'(hll) * int'(vfl) + 7);
    stop_video();
    idle_check("R10 after disable");
  endtask

  task automatic t_polarity();
    hp = 1; vp = 1; cp = 1; bp = 1;
    @(negedge clk);
    idle_check("R8 R10 inverted idle");
    start_video();
    run_compare(int'(hll) * int'(vfl) + 3);
    stop_video();
    hp = 0; vp = 0; cp = 0; bp = 0;
  endtask

  task automatic t_midframe_restart();
    start_video();
    run_compare(57);
    stop_video();
    idle_check("R10 mid-frame stop");
    start_video();
    run_compare(int'(hll) + 2);
    stop_video();
  endtask

  task automatic t_no_sync();
    hsw = 8'd0; vsw = 8'd0;
    hdl = 8'd0; vdl = 8'd0;
    hgl = 16'd4; vgl = 16'd2;
    start_video();
    run_compare(int'(hll) * int'(vfl));
    stop_video();
  endtask

  task automatic t_async_reset();
    start_video();
    run_compare(30);
    #1 rst_n = 1'b0;
    #1 idle_check("R11 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    hsw = 8'd3;  hdl = 8'd5;  hgl = 16'd8;  hll = 16'd20;
    vsw = 8'd2;  vdl = 8'd3;  vgl = 16'd4;  vfl = 16'd10;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_polarity();
    t_midframe_restart();
    t_async_reset();
    hll = 16'd7; vfl = 16'd5;
    t_no_sync();
    done = 1;
    report();
  end
endmodule